// File: doc/BRIEF.md
# Line-Buffered Pixel Stream Bridge

This block sits between a serial pixel stream and a processor array of `LANES` one-pixel lanes. On the capture side, an input shift chain collects one line of `PIX_W`-bit pixels. It does this while the array is still busy with the previous line. On the display side, an output chain sends a finished line out one pixel at a time. Meanwhile the array computes the next line. Neither chain waits on the array's instruction stream. Both sides share one clock, and a per-pixel strobe paces each chain.

The array talks to the bridge through two commands. The load command copies a complete received line into the array-facing register. If the line is not yet complete, the command stalls. The store command copies a line from the array into the output chain. If the chain is still sending the previous line, the command stalls. These two stalls give line-level synchronisation with the camera and the monitor. A one-cycle done pulse ends each command.

Top module: `line_io_bridge`

## Requirements
- R1: Directly after reset, `in_line_ready`, `load_busy`, `load_done`, `store_busy`, `store_done` and `out_valid` are all 0.
- R2: Each cycle with `in_valid` high accepts one pixel. `in_line_ready` rises in the cycle after the `LANES`-th accepted pixel of a line.
- R3: A delivered line holds the k-th pixel accepted since the previous load (counting from 0) in `arr_in_line[k*PIX_W +: PIX_W]`.
- R4: A `cmd_load` pulse that arrives while `in_line_ready` is 1 completes at that clock edge. In the next cycle `load_done` is 1, `in_line_ready` is 0, `load_busy` stays 0, and `arr_in_line` holds the line.
- R5: A `cmd_load` pulse that arrives while no line is ready raises `load_busy` from the next cycle. It stays raised until the transfer, which happens at the first edge where `in_line_ready` is 1. `load_done` appears in the cycle after that edge.
- R6: Pixels that arrive while a complete line waits to be loaded are ignored. The delivered line is unchanged by them.
- R7: A `cmd_store` pulse while `out_valid` is 0 loads `store_line` at that edge. In the next cycle `store_done` is 1, `out_valid` is 1 and `out_pix` shows pixel 0 (bits `[PIX_W-1:0]`).
- R8: The output chain sends pixel k (bits `[k*PIX_W +: PIX_W]`) in order from k = 0. It advances by one pixel on each edge where `out_valid` and `out_ready` are both 1. `out_pix` and `out_valid` hold steady while `out_ready` is 0.
- R9: A `cmd_store` pulse while the output chain is still sending raises `store_busy`. The new line loads at the first edge after the last pixel has left, when `out_valid` is 0. `store_line` must be held until `store_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Capture pixel strobe |
| in_pix | input | PIX_W | Capture pixel |
| in_line_ready | output | 1 | Complete line waiting in the input chain |
| cmd_load | input | 1 | Array command: take the received line (one-cycle pulse) |
| load_busy | output | 1 | Load command stalled waiting for a line |
| load_done | output | 1 | One-cycle pulse: line delivered |
| arr_in_line | output | LANES*PIX_W | Line delivered to the array |
| cmd_store | input | 1 | Array command: send a line (one-cycle pulse) |
| store_line | input | LANES*PIX_W | Line from the array, held until store_done |
| store_busy | output | 1 | Store command stalled behind the sending line |
| store_done | output | 1 | One-cycle pulse: line accepted for sending |
| out_ready | input | 1 | Display pixel strobe |
| out_valid | output | 1 | Output pixel present |
| out_pix | output | PIX_W | Output pixel |

## Verification
Both done pulses are registered, so each is sampled in the cycle after the edge where the transfer fires. That edge is the command edge itself when the line or the chain is already available. Otherwise it is the first edge after the condition becomes true: one cycle after the last captured pixel, or one cycle after the last sent pixel. `in_line_ready` is sampled in the cycle after the final accepted pixel. Inputs change just after a rising edge and outputs are read at the falling edge. Each output pixel is recorded in the cycle where `out_valid` and `out_ready` are both high, before the edge that advances the chain.

// File: rtl/line_io_pkg.sv
// Shared types for the line-buffered pixel bridge.
package line_io_pkg;

    // State of a stalling array-side command.
    typedef enum logic {
        GATE_IDLE = 1'b0,
        GATE_WAIT = 1'b1
    } gate_state_e;

endpackage

// File: rtl/line_in_chain.sv
// Input shift chain: collects LANES pixels of PIX_W bits, pixel 0 ending in
// lane 0. Assumes take is only asserted while full; pixels offered while the
// chain is full are dropped.
module line_in_chain #(
    parameter int LANES = 8,
    parameter int PIX_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pix_vld,
    input  logic [PIX_W-1:0]         pix,
    input  logic                     take,
    output logic                     full,
    output logic [LANES*PIX_W-1:0]   line
);
    localparam int CW = $clog2(LANES + 1);

    logic [CW-1:0]    fill_cnt;
    logic [PIX_W-1:0] stg [LANES];
    logic             shift_en;

    assign full     = (fill_cnt == CW'(LANES));
    assign shift_en = pix_vld && !full;

    // Fill counter: counts accepted pixels, cleared by a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)        fill_cnt <= '0;
        else if (take)     fill_cnt <= '0;
        else if (shift_en) fill_cnt <= fill_cnt + CW'(1);
    end

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_stage
            // Stage register: top lane takes the new pixel, others take the lane above.
            if (g == LANES - 1) begin : g_top
                always_ff @(posedge clk) begin
                    if (!rst_n)        stg[g] <= '0;
                    else if (shift_en) stg[g] <= pix;
                end
            end else begin : g_mid
                always_ff @(posedge clk) begin
                    if (!rst_n)        stg[g] <= '0;
                    else if (shift_en) stg[g] <= stg[g+1];
                end
            end
            assign line[g*PIX_W +: PIX_W] = stg[g];
        end
    endgenerate
endmodule

// File: rtl/line_out_chain.sv
// Output shift chain: loads LANES pixels in parallel, then presents them
// lane 0 first, advancing on each accepted strobe. Assumes load is only
// asserted while empty.
module line_out_chain #(
    parameter int LANES = 8,
    parameter int PIX_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [LANES*PIX_W-1:0]   line,
    input  logic                     adv,
    output logic                     vld,
    output logic [PIX_W-1:0]         pix
);
    localparam int CW = $clog2(LANES + 1);

    logic [CW-1:0]    left_cnt;
    logic [PIX_W-1:0] stg [LANES];
    logic             step;

    assign vld  = (left_cnt != '0);
    assign pix  = stg[0];
    assign step = adv && vld;

    // Remaining-pixel counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    left_cnt <= '0;
        else if (load) left_cnt <= CW'(LANES);
        else if (step) left_cnt <= left_cnt - CW'(1);
    end

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_stage
            // Stage register: parallel load or shift toward lane 0.
            if (g == LANES - 1) begin : g_top
                always_ff @(posedge clk) begin
                    if (!rst_n)    stg[g] <= '0;
                    else if (load) stg[g] <= line[g*PIX_W +: PIX_W];
                    else if (step) stg[g] <= '0;
                end
            end else begin : g_mid
                always_ff @(posedge clk) begin
                    if (!rst_n)    stg[g] <= '0;
                    else if (load) stg[g] <= line[g*PIX_W +: PIX_W];
                    else if (step) stg[g] <= stg[g+1];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/xfer_gate.sv
// Stalling command gate: a one-cycle req either fires at once when ok is
// high or waits (busy) until ok rises; done pulses the cycle after firing.
module xfer_gate
    import line_io_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic ok,
    output logic fire,
    output logic busy,
    output logic done
);
    gate_state_e st;

    assign fire = (req || (st == GATE_WAIT)) && ok;
    assign busy = (st == GATE_WAIT);

    // Wait state: entered on an unserved request, left on firing.
    always_ff @(posedge clk) begin
        if (!rst_n)    st <= GATE_IDLE;
        else if (fire) st <= GATE_IDLE;
        else if (req)  st <= GATE_WAIT;
    end

    // Completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= fire;
    end
endmodule

// File: rtl/line_io_bridge.sv
// Top: serial-to-parallel and parallel-to-serial line bridge between a pixel
// stream and a LANES-wide array. Single clock; pixel strobes act as enables.
module line_io_bridge #(
    parameter int LANES = 8,
    parameter int PIX_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [PIX_W-1:0]         in_pix,
    output logic                     in_line_ready,
    input  logic                     cmd_load,
    output logic                     load_busy,
    output logic                     load_done,
    output logic [LANES*PIX_W-1:0]   arr_in_line,
    input  logic                     cmd_store,
    input  logic [LANES*PIX_W-1:0]   store_line,
    output logic                     store_busy,
    output logic                     store_done,
    input  logic                     out_ready,
    output logic                     out_valid,
    output logic [PIX_W-1:0]         out_pix
);
    localparam int LW = LANES * PIX_W;

    logic          load_fire;
    logic          store_fire;
    logic [LW-1:0] in_line;

    line_in_chain #(.LANES(LANES), .PIX_W(PIX_W)) u_in (
        .clk(clk), .rst_n(rst_n), .pix_vld(in_valid), .pix(in_pix),
        .take(load_fire), .full(in_line_ready), .line(in_line)
    );

    xfer_gate u_load_gate (
        .clk(clk), .rst_n(rst_n), .req(cmd_load), .ok(in_line_ready),
        .fire(load_fire), .busy(load_busy), .done(load_done)
    );

    // Array-facing line register, written on each load transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)         arr_in_line <= '0;
        else if (load_fire) arr_in_line <= in_line;
    end

    xfer_gate u_store_gate (
        .clk(clk), .rst_n(rst_n), .req(cmd_store), .ok(!out_valid),
        .fire(store_fire), .busy(store_busy), .done(store_done)
    );

    line_out_chain #(.LANES(LANES), .PIX_W(PIX_W)) u_out (
        .clk(clk), .rst_n(rst_n), .load(store_fire), .line(store_line),
        .adv(out_ready), .vld(out_valid), .pix(out_pix)
    );
endmodule

// File: rtl/line_io_bridge_chk.sv
// Port-level temporal checks for line_io_bridge, attached by bind.
module line_io_bridge_chk #(
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_line_ready,
    input logic             load_done,
    input logic             store_done,
    input logic             out_ready,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_pix
);
    AST_LOAD_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> !in_line_ready);                                   // R4
    AST_LOAD_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> $past(in_line_ready));                             // R5
    AST_STORE_STARTS_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        store_done |-> out_valid);                                       // R7
    AST_STORE_AFTER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        store_done |-> !$past(out_valid));                               // R9
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));  // R8
endmodule

bind line_io_bridge line_io_bridge_chk #(.PIX_W(PIX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_line_ready(in_line_ready),
    .load_done(load_done), .store_done(store_done), .out_ready(out_ready),
    .out_valid(out_valid), .out_pix(out_pix)
);

// File: tb/sim_line_io_bridge.sv
module sim_line_io_bridge;
    localparam int LANES = 8;
    localparam int PIX_W = 8;
    localparam int LW    = LANES * PIX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [PIX_W-1:0] in_pix = '0;
    logic in_line_ready;
    logic cmd_load = 1'b0;
    logic load_busy, load_done;
    logic [LW-1:0] arr_in_line;
    logic cmd_store = 1'b0;
    logic [LW-1:0] store_line = '0;
    logic store_busy, store_done;
    logic out_ready = 1'b0;
    logic out_valid;
    logic [PIX_W-1:0] out_pix;

    int n_vec = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;
    logic [LW-1:0] exp_line;
    int seed_dummy;

    always #2 clk = ~clk;

    line_io_bridge #(.LANES(LANES), .PIX_W(PIX_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .in_line_ready(in_line_ready), .cmd_load(cmd_load),
        .load_busy(load_busy), .load_done(load_done), .arr_in_line(arr_in_line),
        .cmd_store(cmd_store), .store_line(store_line), .store_busy(store_busy),
        .store_done(store_done), .out_ready(out_ready), .out_valid(out_valid),
        .out_pix(out_pix)
    );

    task automatic chk(input bit ok, input string req, input logic [LW-1:0] act,
                       input logic [LW-1:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [LW-1:0] rand_line();
        logic [LW-1:0] v;
        for (int k = 0; k < LANES; k++) v[k*PIX_W +: PIX_W] = PIX_W'($urandom);
        return v;
    endfunction

    function automatic logic [PIX_W-1:0] lane_of(input logic [LW-1:0] l, input int k);
        return l[k*PIX_W +: PIX_W];
    endfunction

    // Push one pixel; returns after the accepting edge.
    task automatic push(input logic [PIX_W-1:0] p);
        in_valid = 1'b1;
        in_pix   = p;
        tick();
        in_valid = 1'b0;
    endtask

    // Send a whole line, optional random gaps.
    task automatic send_line(input logic [LW-1:0] l, input bit gaps);
        for (int k = 0; k < LANES; k++) begin
            push(lane_of(l, k));
            if (gaps && ($urandom % 3 == 0)) tick();
        end
    endtask

    // Load when a line is already ready (R4, R3).
    task automatic load_now(input logic [LW-1:0] l, input string tag);
        @(negedge clk);
        chk(in_line_ready == 1'b1, "R2 ready after line", LW'(in_line_ready), LW'(1));
        @(posedge clk); #1;
        cmd_load = 1'b1;
        tick();
        cmd_load = 1'b0;
        @(negedge clk);
        chk(load_done && !load_busy && !in_line_ready, "R4 immediate load",
            LW'({load_done, load_busy, in_line_ready}), LW'(3'b100));
        chk(arr_in_line == l, tag, arr_in_line, l);
        @(posedge clk); #1;
    endtask

    // Drain the output chain; random or steady ready. Checks order (R8).
    task automatic drain(input logic [LW-1:0] l, input bit rnd);
        int got = 0;
        logic [PIX_W-1:0] held;
        bit held_v = 1'b0;
        while (got < LANES) begin
            out_ready = rnd ? 1'($urandom) : 1'b1;
            @(negedge clk);
            if (held_v) begin
                chk(out_valid && out_pix == held, "R8 hold while not ready",
                    LW'(out_pix), LW'(held));
                held_v = 1'b0;
            end
            if (out_valid && out_ready) begin
                chk(out_pix == lane_of(l, got), "R8 output order",
                    LW'(out_pix), LW'(lane_of(l, got)));
                got++;
            end else if (out_valid) begin
                held = out_pix;
                held_v = 1'b1;
            end
            @(posedge clk); #1;
        end
        out_ready = 1'b0;
    endtask

    // Store into an empty output chain (R7).
    task automatic store_now(input logic [LW-1:0] l);
        store_line = l;
        cmd_store  = 1'b1;
        tick();
        cmd_store  = 1'b0;
        @(negedge clk);
        chk(store_done && out_valid && !store_busy, "R7 immediate store",
            LW'({store_done, out_valid, store_busy}), LW'(3'b110));
        chk(out_pix == lane_of(l, 0), "R7 pixel 0 first", LW'(out_pix), LW'(lane_of(l, 0)));
        @(posedge clk); #1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [LW-1:0] l1, l2;
        seed_dummy = $urandom(32'h1234_5678);
        repeat (3) tick();
        rst_n = 1'b1;
        @(negedge clk);
        chk({in_line_ready, load_busy, load_done, store_busy, store_done, out_valid} == 6'b0,
            "R1 reset state", LW'({in_line_ready, load_busy, load_done, store_busy,
            store_done, out_valid}), '0);
        @(posedge clk); #1;

        // R2/R3: fill a line with gaps, ready only after the last pixel.
        l1 = rand_line();
        for (int k = 0; k < LANES; k++) begin
            @(negedge clk);
            chk(!in_line_ready, "R2 not ready mid-line", LW'(in_line_ready), '0);
            @(posedge clk); #1;
            push(lane_of(l1, k));
        end
        load_now(l1, "R3 line packing");

        // R5: load requested before any pixel.
        l1 = rand_line();
        cmd_load = 1'b1;
        tick();
        cmd_load = 1'b0;
        @(negedge clk);
        chk(load_busy && !load_done, "R5 stall busy", LW'({load_busy, load_done}), LW'(2'b10));
        @(posedge clk); #1;
        for (int k = 0; k < LANES; k++) push(lane_of(l1, k));
        @(negedge clk);
        chk(in_line_ready && load_busy && !load_done, "R5 still busy at ready",
            LW'({in_line_ready, load_busy, load_done}), LW'(3'b110));
        @(posedge clk); #1;
        @(negedge clk);
        chk(load_done && !load_busy, "R5 done edge after ready",
            LW'({load_done, load_busy}), LW'(2'b10));
        chk(arr_in_line == l1, "R5 line data", arr_in_line, l1);
        @(posedge clk); #1;

        // R6: extra pixels while full are ignored.
        l1 = rand_line();
        send_line(l1, 1'b0);
        for (int k = 0; k < 3; k++) push(PIX_W'($urandom));
        load_now(l1, "R6 extras ignored");

        // R7/R8: store and drain steady, then with backpressure.
        l1 = rand_line();
        store_now(l1);
        drain(l1, 1'b0);
        l1 = rand_line();
        store_now(l1);
        drain(l1, 1'b1);

        // R9: second store while the first line is sending.
        l1 = rand_line();
        l2 = rand_line();
        store_now(l1);
        store_line = l2;
        cmd_store  = 1'b1;
        tick();
        cmd_store  = 1'b0;
        @(negedge clk);
        chk(store_busy && !store_done, "R9 stall busy", LW'({store_busy, store_done}), LW'(2'b10));
        @(posedge clk); #1;
        drain(l1, 1'b0);
        @(negedge clk);
        chk(!out_valid && store_busy && !store_done, "R9 waits for empty",
            LW'({out_valid, store_busy, store_done}), LW'(3'b010));
        @(posedge clk); #1;
        @(negedge clk);
        chk(store_done && out_valid && out_pix == lane_of(l2, 0), "R9 loads after empty",
            LW'(out_pix), LW'(lane_of(l2, 0)));
        @(posedge clk); #1;
        drain(l2, 1'b1);

        // Random mix of capture/load and store/drain.
        for (int it = 0; it < 20; it++) begin
            l1 = rand_line();
            send_line(l1, 1'b1);
            load_now(l1, "R3 random line");
            l2 = rand_line();
            store_now(l2);
            drain(l2, 1'b1);
        end

        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule